// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block sits on a two-wire serial bus as a slave and behaves like a small serial memory of 256 bytes. A synchronous system clock oversamples the bus clock and data lines. The block detects start and stop conditions and answers only to its own 7-bit device address. It pulls the data line low, as an open-drain driver, to acknowledge bytes and to return read data.

One 8-bit location pointer serves both directions, and it keeps its value from one transaction to the next. In a write transaction the first byte after the device address loads the pointer. Each later byte is stored at the pointer, which then steps forward. A read transaction streams bytes out starting at the pointer and steps the pointer after every byte. A master therefore selects a location with a short write transaction and then reads with one or more separate read transactions. A write-protect input stops the array from changing while the bus exchange continues as normal. The pointer is brought out as a port so that a bench or a neighbouring block can watch it.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset the slave does not drive the data line (`sda_oe` = 0) and the pointer output reads 0.
- R2: A transaction whose 7-bit address (sent MSB first, followed by the R/W bit in the LSB) differs from `DEV_ADDR` gets no acknowledge. The slave ignores the rest of it: no store, and no pointer change.
- R3: In a write transaction (R/W bit = 0), the first byte after the device address is loaded into the pointer and is acknowledged.
- R4: Each later byte of the same write transaction is acknowledged and stored at the pointer, and the pointer then increments.
- R5: The pointer keeps its value across stop and start conditions. After a write it holds one past the last byte stored, or the loaded value if no data byte followed.
- R6: A read transaction (R/W bit = 1) returns bytes MSB first, starting at the pointer. The pointer increments after each byte, whether the reads fall in one transaction or in several.
- R7: The pointer wraps from 255 to 0, for both writing and reading.
- R8: While `wp_i` = 1, data bytes are still acknowledged and the pointer still advances, but the stored contents do not change.
- R9: A stop or start condition seen part-way through a byte abandons that byte. Nothing is stored and the pointer does not move. A start condition begins a new device-address phase.
- R10: A master NACK after a read byte ends data output. The slave leaves the data line released through any further clocks until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND result) |
| sda_oe | output | 1 | 1 = pull the data line low; 0 = release it |
| wp_i | input | 1 | Write protect: 1 blocks changes to the array |
| ptr_o | output | 8 | Current value of the location pointer |

## Verification
The bench goes after the pointer's life across transaction boundaries. It checks a write that only loads the pointer, then separate read transactions that must continue from where the last one stopped. A design that reset the pointer on stop, or advanced it only within one transaction, would return the wrong bytes. It also exercises the wrap from 255 to 0, write protection, a stop or a repeated start inside a byte, and a foreign device address. A wrong design would show up as follows: a missing wrap misreads location 0, a leaky protect alters stored data, and a design that commits partial bytes moves the pointer. The bench also toggles the clock after a master NACK, so a slave that keeps driving would pull the released line low.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_ACK_DEV,
        S_RX,
        S_ACK_RX,
        S_TX,
        S_RACK,
        S_TNEXT
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [CNT_W-1:0]    bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic                rw;
        logic                first;
        logic [PTR_W-1:0]    ptr;
        logic                sda_oe;
    } ctrl_s;

endpackage

// File: rtl/i2c_ee_line_mon.sv
module i2c_ee_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int HIST = SYNC_STAGES + 1;

    logic [HIST-1:0] scl_h_q, scl_h_d;
    logic [HIST-1:0] sda_h_q, sda_h_d;

    always_comb begin
        scl_h_d = {scl_h_q[HIST-2:0], scl_i};
        sda_h_d = {sda_h_q[HIST-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_h_q <= '1;
            sda_h_q <= '1;
        end else begin
            scl_h_q <= scl_h_d;
            sda_h_q <= sda_h_d;
        end
    end

    // newest synchronized sample is index HIST-2, previous is HIST-1
    logic scl_now, scl_old, sda_now, sda_old;
    always_comb begin
        scl_now   = scl_h_q[HIST-2];
        scl_old   = scl_h_q[HIST-1];
        sda_now   = sda_h_q[HIST-2];
        sda_old   = sda_h_q[HIST-1];
        sda_s     = sda_now;
        scl_rise  = scl_now && !scl_old;
        scl_fall  = !scl_now && scl_old;
        start_det = scl_now && scl_old && sda_old && !sda_now;
        stop_det  = scl_now && scl_old && !sda_old && sda_now;
    end

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = cells_q[raddr];
    end

endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
    import i2c_ee_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             wp_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_ee_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ctrl_s             r_q, r_d;
    logic              mem_we;
    logic              ptr_load;
    logic [BYTE_W-1:0] rdata;

    i2c_ee_store #(.ADDR_W(PTR_W), .DATA_W(BYTE_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (r_q.ptr),
        .wdata (r_q.shreg),
        .raddr (r_q.ptr),
        .rdata (rdata)
    );

    always_comb begin
        r_d      = r_q;
        mem_we   = 1'b0;
        ptr_load = 1'b0;
        if (start_det) begin
            r_d.st     = S_DEV;
            r_d.bitcnt = '0;
            r_d.sda_oe = 1'b0;
        end else if (stop_det) begin
            r_d.st     = S_IDLE;
            r_d.bitcnt = '0;
            r_d.sda_oe = 1'b0;
        end else begin
            case (r_q.st)
                S_DEV, S_RX: begin
                    if (scl_rise && r_q.bitcnt < FULL) begin
                        r_d.shreg  = {r_q.shreg[BYTE_W-2:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (scl_fall && r_q.bitcnt == FULL) begin
                        r_d.bitcnt = '0;
                        if (r_q.st == S_DEV) begin
                            if (r_q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                r_d.st     = S_ACK_DEV;
                                r_d.sda_oe = 1'b1;
                                r_d.rw     = r_q.shreg[0];
                            end else begin
                                r_d.st = S_IDLE;
                            end
                        end else begin
                            r_d.st     = S_ACK_RX;
                            r_d.sda_oe = 1'b1;
                            if (r_q.first) begin
                                r_d.ptr   = r_q.shreg;
                                r_d.first = 1'b0;
                                ptr_load  = 1'b1;
                            end else begin
                                mem_we    = !wp_i;
                                r_d.ptr   = r_q.ptr + 1'b1;
                            end
                        end
                    end
                end
                S_ACK_DEV: begin
                    if (scl_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.rw) begin
                            r_d.st     = S_TX;
                            r_d.shreg  = rdata;
                            r_d.sda_oe = !rdata[BYTE_W-1];
                        end else begin
                            r_d.st     = S_RX;
                            r_d.sda_oe = 1'b0;
                            r_d.first  = 1'b1;
                        end
                    end
                end
                S_ACK_RX: begin
                    if (scl_fall) begin
                        r_d.st     = S_RX;
                        r_d.sda_oe = 1'b0;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (r_q.bitcnt == LAST) begin
                            r_d.sda_oe = 1'b0;
                            r_d.st     = S_RACK;
                        end else begin
                            r_d.shreg  = {r_q.shreg[BYTE_W-2:0], 1'b0};
                            r_d.sda_oe = !r_q.shreg[BYTE_W-2];
                            r_d.bitcnt = r_q.bitcnt + 1'b1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        r_d.ptr = r_q.ptr + 1'b1;
                        r_d.st  = sda_s ? S_IDLE : S_TNEXT;
                    end
                end
                S_TNEXT: begin
                    if (scl_fall) begin
                        r_d.st     = S_TX;
                        r_d.bitcnt = '0;
                        r_d.shreg  = rdata;
                        r_d.sda_oe = !rdata[BYTE_W-1];
                    end
                end
                default: r_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, bitcnt: '0, shreg: '0, rw: 1'b0,
                     first: 1'b0, ptr: '0, sda_oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.sda_oe;
    assign ptr_o  = r_q.ptr;

    // R9 R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && r_q.st == S_IDLE));

    // R9
    start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (r_q.st == S_DEV && r_q.bitcnt == '0));

    // R4 R5 R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_o != $past(ptr_o)) |-> (ptr_o == $past(ptr_o) + 1'b1 || $past(ptr_load)));

    // R4 R8
    ack_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ACK_RX && $past(r_q.st) == S_RX) |-> sda_oe);

    // R9
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bitcnt <= FULL);

endmodule

// File: tb/i2c_ee_slave_tb.sv
module i2c_ee_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [6:0] DEV = 7'h50;
    localparam int NV = 6;
    // {address, data}
    localparam logic [15:0] VEC [NV] = '{16'h003C, 16'h05A5, 16'h7F5A,
                                         16'h80C3, 16'hFE01, 16'hFFE7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic [7:0] ptr;
    logic sda_line;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ee_slave #(.DEV_ADDR(DEV)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .wp_i   (wp),
        .ptr_o  (ptr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(2);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; w(Q); scl = 1'b1; w(Q); scl = 1'b0; w(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; w(Q); scl = 1'b1; w(Q/2); ack = sda_line; w(Q/2); scl = 1'b0; w(2);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl = 1'b1; w(Q/2); d[i] = sda_line; w(Q/2); scl = 1'b0; w(2);
        end
        sda_m = nack; w(Q); scl = 1'b1; w(Q); scl = 1'b0; w(2); sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic ack;
        i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(a, ack); i2c_stop();
    endtask

    task automatic read1(output logic [7:0] d);
        logic ack;
        i2c_start(); send_byte({DEV, 1'b1}, ack); recv_byte(1'b1, d); i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack, ack2;
        logic [7:0] d, d2;
        w(5); rst_n = 1'b1; w(5);
        // R1 reset state
        chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
        chk("R1 ptr", ptr, 8'h00);

        // table: single-byte writes then readback
        for (int k = 0; k < NV; k++) begin
            i2c_start();
            send_byte({DEV, 1'b0}, ack); chk("R3 dev ack", {7'd0, ack}, 8'h00);
            send_byte(VEC[k][15:8], ack); chk("R3 addr ack", {7'd0, ack}, 8'h00);
            send_byte(VEC[k][7:0], ack);  chk("R4 data ack", {7'd0, ack}, 8'h00);
            i2c_stop();
            chk("R5 R7 ptr after write", ptr, VEC[k][15:8] + 8'd1);
        end
        for (int k = 0; k < NV; k++) begin
            set_ptr(VEC[k][15:8]);
            chk("R5 ptr after load only", ptr, VEC[k][15:8]);
            read1(d);
            chk("R6 read data", d, VEC[k][7:0]);
            chk("R6 R7 ptr after read", ptr, VEC[k][15:8] + 8'd1);
        end

        // R4 multi-byte write, R6 reads split over transactions
        i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h20, ack);
        send_byte(8'hA1, ack); send_byte(8'hA2, ack); send_byte(8'hA3, ack); i2c_stop();
        chk("R4 ptr after 3 bytes", ptr, 8'h23);
        set_ptr(8'h20);
        i2c_start(); send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, d); recv_byte(1'b1, d2); i2c_stop();
        chk("R6 burst byte0", d, 8'hA1);
        chk("R6 burst byte1", d2, 8'hA2);
        read1(d);
        chk("R6 continues across transactions", d, 8'hA3);
        chk("R6 ptr", ptr, 8'h23);

        // R7 read wrap 0xFF -> 0x00
        set_ptr(8'hFF);
        i2c_start(); send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, d); recv_byte(1'b1, d2); i2c_stop();
        chk("R7 byte at FF", d, 8'hE7);
        chk("R7 byte at 00 after wrap", d2, 8'h3C);
        chk("R7 ptr wrapped", ptr, 8'h01);

        // R2 foreign address ignored
        i2c_start(); send_byte({7'h51, 1'b0}, ack);
        send_byte(8'h05, ack2); send_byte(8'h99, ack2); i2c_stop();
        chk("R2 no ack", {7'd0, ack}, 8'h01);
        chk("R2 no data ack", {7'd0, ack2}, 8'h01);
        chk("R2 ptr unchanged", ptr, 8'h01);
        set_ptr(8'h05); read1(d);
        chk("R2 memory unchanged", d, 8'hA5);

        // R8 write protect
        wp = 1'b1;
        i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h20, ack);
        send_byte(8'h55, ack); i2c_stop();
        chk("R8 ack while protected", {7'd0, ack}, 8'h00);
        chk("R8 ptr advances", ptr, 8'h21);
        wp = 1'b0;
        set_ptr(8'h20); read1(d);
        chk("R8 data kept", d, 8'hA1);

        // R9 stop mid-byte
        i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h21, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        i2c_stop();
        chk("R9 ptr after stop mid-byte", ptr, 8'h21);
        read1(d);
        chk("R9 partial byte not stored", d, 8'hA2);
        // R9 repeated start mid-byte
        i2c_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h22, ack);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        i2c_start(); send_byte({DEV, 1'b1}, ack);
        chk("R9 ack after restart", {7'd0, ack}, 8'h00);
        recv_byte(1'b1, d); i2c_stop();
        chk("R9 read after restart", d, 8'hA3);

        // R10 release after NACK
        set_ptr(8'h80);
        i2c_start(); send_byte({DEV, 1'b1}, ack); recv_byte(1'b1, d);
        chk("R10 data before nack", d, 8'hC3);
        sda_m = 1'b1; w(Q); scl = 1'b1; w(Q/2);
        chk("R10 line released", {7'd0, sda_line}, 8'h01);
        chk("R10 sda_oe low", {7'd0, sda_oe}, 8'h00);
        w(Q/2); scl = 1'b0; w(Q);
        chk("R10 still released", {7'd0, sda_oe}, 8'h00);
        i2c_stop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule